// File: doc/BRIEF.md
# Prescaled General-Purpose Compare Timer

This block is an up-counting timer with a word-addressed register window. A control register picks one of two tick sources (both arrive as single-cycle enables that are synchronous to the block clock), and a 12-bit divider passes one count step through for every (divisor + 1) source ticks. Three compare registers raise status flags when the counter reaches them, and a wrap of the counter from all-ones to zero raises a rollover flag. The interrupt line follows the flags, their enables and the global enable.

Two counting styles exist. In restart mode the first compare register acts as the period: the count returns to zero one step after it matches, and writing that register zeroes the count. In free-run mode the count runs through every match up to the wrap. A software reset bit clears most of the block while keeping the clock-source selection, the mode bit and the upper control bits.

A two-state machine, `TM_HALT` and `TM_COUNT`, holds the global enable. `TM_HALT` moves to `TM_COUNT` on a control write with the enable bit set and the reset bit clear (the *start* transition). `TM_COUNT` moves back to `TM_HALT` on a control write with the enable bit clear or the reset bit set (the *stop* transition). Every other cycle keeps the state.

Top module: `cmp_timer`

## Requirements
- R1: After hardware reset the control, divisor, status, enable-mask, capture and counter registers read 0, each compare register reads all ones at counter width, and `irq` is low.
- R2: The word index is `addr` shifted right by 2: 0 control, 1 divisor, 2 status, 3 interrupt mask, 4/5/6 compare 1/2/3, 7/8 capture (always read 0), 9 counter. Any other index, and any address whose low two bits are nonzero, reads 0, and writes to it change nothing.
- R3: The divisor register keeps the low 12 bits of a write. While counting, the counter gains one for every (divisor + 1) selected source ticks. The divider phase restarts at zero on a divisor write, a counter zeroing, or while halted.
- R4: Control bits 8:6 choose the source: 001 and 010 select `tick_fast`, 100 selects `tick_slow`, and every other code selects nothing, so the counter holds.
- R5: Status bits are bit 0/1/2 for compare 1/2/3 and bit 5 for rollover. Writing status clears each flag whose bit in `wdata[5:0]` is 1 and leaves the others unchanged.
- R6: The interrupt mask stores 6 bits. `irq` is high exactly when (status AND mask) is nonzero and the block is in `TM_COUNT`.
- R7: A control write stores the value with bits 2, 4 and 10 to 14 forced to 0. Bit 0 is the enable, bit 1 the zero-on-start bit, bit 9 the free-run bit, and bit 15 the software reset, which always reads 0.
- R8: A control write with bit 15 set clears control bits 0 to 5, clears the status, divisor, mask and counter, sets all compare registers to all ones, and leaves control bits 6 to 9 and 16 to 31 as written.
- R9: A start transition with bit 1 set zeroes the counter. With bit 1 clear the counter resumes from its held value. In `TM_HALT` the counter does not move.
- R10: In restart mode (bit 9 clear), a write to compare 1 zeroes the counter. In free-run mode it leaves the counter alone.
- R11: A compare flag is set on the step that brings the counter to that compare value.
- R12: The rollover flag is set on the step that takes the counter from all ones to zero.
- R13: In restart mode a step taken while the counter equals compare 1 reloads it to zero. In free-run mode every step adds one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_fast | input | 1 | Peripheral-rate tick enable |
| tick_slow | input | 1 | Low-rate (32 kHz) tick enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with an 8-bit counter, the 12-bit divisor and a 12-bit address. This brings the all-ones to zero wrap within 256 ticks, so the rollover flag, the restart reload and the compare flags can all be driven through a full counter period. The bench sweeps all eight clock-source codes and a range of divisors and tick counts, and predicts each counter value arithmetically as the tick count divided by (divisor + 1).

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;

    localparam int REG_W     = 32;
    localparam int NUM_CMP   = 3;
    localparam int NUM_FLAGS = 6;

    // word indices of the register window
    typedef enum logic [3:0] {
        IDX_CTRL = 4'd0,
        IDX_DIV  = 4'd1,
        IDX_STAT = 4'd2,
        IDX_MASK = 4'd3,
        IDX_CMP1 = 4'd4,
        IDX_CMP2 = 4'd5,
        IDX_CMP3 = 4'd6,
        IDX_CAP1 = 4'd7,
        IDX_CAP2 = 4'd8,
        IDX_CNT  = 4'd9
    } reg_idx_e;

    // control bit positions
    localparam int C_EN   = 0;
    localparam int C_ZST  = 1;
    localparam int C_SRC  = 6;
    localparam int C_FREE = 9;
    localparam int C_SWR  = 15;

    // bits forced to zero on every control write (includes self-clearing reset)
    localparam logic [REG_W-1:0] CTRL_DROP = 32'h0000_FC14;
    // bits cleared by the software reset
    localparam logic [REG_W-1:0] CTRL_SOFT = 32'h0000_003F;

    typedef enum logic {TM_HALT, TM_COUNT} tm_state_e;

    function automatic logic pick_tick(input logic [2:0] sel,
                                       input logic fast,
                                       input logic slow);
        case (sel)
            3'b001, 3'b010: return fast;
            3'b100:         return slow;
            default:        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cmt_prescale.sv
`timescale 1ns/1ps
module cmt_prescale #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             src_tick,
    input  logic [PRE_W-1:0] div,
    output logic             step
);

    logic [PRE_W-1:0] phase_q;
    logic             at_end;

    assign at_end = (phase_q == div);
    assign step   = !hold && src_tick && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (hold) begin
            phase_q <= '0;
        end else if (src_tick) begin
            phase_q <= at_end ? '0 : phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/cmt_count.sv
`timescale 1ns/1ps
module cmt_count #(
    parameter int CNT_W = 32,
    parameter int NCMP  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             zero,
    input  logic             freerun,
    input  logic [CNT_W-1:0] cmp [NCMP],
    output logic [CNT_W-1:0] cnt,
    output logic [NCMP-1:0]  hit,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nxt;
    logic             reload;
    logic             live;

    assign live   = step && !zero;
    assign reload = !freerun && (cnt_q == cmp[0]);
    assign nxt    = reload ? '0 : cnt_q + 1'b1;
    assign wrap   = live && (cnt_q == CNT_MAX);
    assign cnt    = cnt_q;

    for (genvar g = 0; g < NCMP; g++) begin : g_hit
        assign hit[g] = live && (nxt == cmp[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (zero) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= nxt;
        end
    end

endmodule

// File: rtl/cmp_timer.sv
`timescale 1ns/1ps
module cmp_timer
    import cmt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 12,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_fast,
    input  logic              tick_slow,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              irq
);

    localparam int IDX_W = ADDR_W - 2;

    // address decode
    logic [IDX_W-1:0] widx;
    logic             in_map;
    logic [15:0]      sel_vec;
    logic [15:0]      wr_sel;

    assign widx   = addr[ADDR_W-1:2];
    assign in_map = (addr[1:0] == 2'b00) && (widx[IDX_W-1:4] == '0);

    always_comb begin
        sel_vec = '0;
        sel_vec[widx[3:0]] = in_map;
    end
    assign wr_sel = sel_vec & {16{wr_en}};

    // stored state
    tm_state_e              state_q, state_d;
    logic [REG_W-1:1]       cr_q;
    logic [PRE_W-1:0]       div_q;
    logic [NUM_FLAGS-1:0]   sr_q;
    logic [NUM_FLAGS-1:0]   mask_q;
    logic [CNT_W-1:0]       cmp_q [NUM_CMP];

    logic                   wr_ctrl, wr_swr, running, start_zero, zero_req;
    logic                   free_run, src, cnt_step, wrap;
    logic [NUM_CMP-1:0]     hit;
    logic [CNT_W-1:0]       cnt_q;
    logic [NUM_FLAGS-1:0]   flag_set, flag_clr;
    logic [REG_W-1:0]       ctrl_keep;

    assign wr_ctrl   = wr_sel[IDX_CTRL];
    assign wr_swr    = wr_ctrl && wdata[C_SWR];
    assign ctrl_keep = wdata & ~CTRL_DROP & ~(wr_swr ? CTRL_SOFT : '0);
    assign free_run  = cr_q[C_FREE];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TM_HALT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TM_HALT:  if (wr_ctrl && !wdata[C_SWR] && wdata[C_EN])   state_d = TM_COUNT;
            TM_COUNT: if (wr_ctrl && (wdata[C_SWR] || !wdata[C_EN])) state_d = TM_HALT;
        endcase
    end

    // state outputs
    always_comb begin
        running    = (state_q == TM_COUNT);
        start_zero = (state_q == TM_HALT) && wr_ctrl && !wdata[C_SWR]
                     && wdata[C_EN] && wdata[C_ZST];
        irq        = running && |(sr_q & mask_q);
    end

    assign zero_req = wr_swr || start_zero || (wr_sel[IDX_CMP1] && !free_run);
    assign src      = pick_tick(cr_q[C_SRC+2:C_SRC], tick_fast, tick_slow);

    cmt_prescale #(.PRE_W(PRE_W)) i_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (!running || zero_req || wr_sel[IDX_DIV]),
        .src_tick (src),
        .div      (div_q),
        .step     (cnt_step)
    );

    cmt_count #(.CNT_W(CNT_W), .NCMP(NUM_CMP)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (cnt_step),
        .zero    (zero_req),
        .freerun (free_run),
        .cmp     (cmp_q),
        .cnt     (cnt_q),
        .hit     (hit),
        .wrap    (wrap)
    );

    assign flag_set = {wrap, 2'b00, hit};
    assign flag_clr = wr_sel[IDX_STAT] ? wdata[NUM_FLAGS-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cr_q   <= '0;
            div_q  <= '0;
            sr_q   <= '0;
            mask_q <= '0;
        end else begin
            sr_q <= (sr_q & ~flag_clr) | flag_set;
            if (wr_ctrl)          cr_q   <= ctrl_keep[REG_W-1:1];
            if (wr_sel[IDX_DIV])  div_q  <= wdata[PRE_W-1:0];
            if (wr_sel[IDX_MASK]) mask_q <= wdata[NUM_FLAGS-1:0];
            if (wr_swr) begin
                sr_q   <= '0;
                div_q  <= '0;
                mask_q <= '0;
            end
        end
    end

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               cmp_q[g] <= '1;
            else if (wr_swr)                          cmp_q[g] <= '1;
            else if (wr_sel[4'(int'(IDX_CMP1) + g)])  cmp_q[g] <= wdata[CNT_W-1:0];
        end
    end

    // read path
    always_comb begin
        rdata = '0;
        if (in_map) begin
            case (widx[3:0])
                IDX_CTRL: rdata = {cr_q, running};
                IDX_DIV:  rdata = REG_W'(div_q);
                IDX_STAT: rdata = REG_W'(sr_q);
                IDX_MASK: rdata = REG_W'(mask_q);
                IDX_CMP1: rdata = REG_W'(cmp_q[0]);
                IDX_CMP2: rdata = REG_W'(cmp_q[1]);
                IDX_CMP3: rdata = REG_W'(cmp_q[2]);
                IDX_CNT:  rdata = REG_W'(cnt_q);
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/cmt_chk.sv
`timescale 1ns/1ps
module cmt_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             running,
    input logic             step,
    input logic             zero_req,
    input logic             wr_swr,
    input logic             freerun,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp1,
    input logic [5:0]       sr
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !irq);

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !zero_req) |=> $stable(cnt));

    // R8
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_swr |=> (cnt == '0 && sr == '0 && !running));

    // R12
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !zero_req && cnt == CNT_MAX) |=> sr[5]);

    // R13
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !zero_req && !freerun && cnt == cmp1) |=> (cnt == '0));

    // R13
    free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !zero_req && freerun) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

endmodule

bind cmp_timer cmt_chk #(.CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .running  (running),
    .step     (cnt_step),
    .zero_req (zero_req),
    .wr_swr   (wr_swr),
    .freerun  (free_run),
    .cnt      (cnt_q),
    .cmp1     (cmp_q[0]),
    .sr       (sr_q)
);

// File: tb/test_cmp_timer.sv
`timescale 1ns/1ps
module test_cmp_timer;

    localparam int CNT_W  = 8;
    localparam int PRE_W  = 12;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_fast = 1'b0;
    logic              tick_slow = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cmp_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) i_cmp_timer (
        .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr_addr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        wr_addr(idx * 4, d);
    endtask

    task automatic rd_addr(input int a, output logic [31:0] v);
        @(negedge clk);
        addr = ADDR_W'(a);
        #1 v = rdata;
    endtask

    task automatic rd_chk(input string req, input int idx, input logic [31:0] exp);
        logic [31:0] v;
        rd_addr(idx * 4, v);
        chk(req, v, exp);
    endtask

    task automatic fast(input int n);
        repeat (n) begin @(negedge clk); tick_fast = 1'b1; end
        @(negedge clk); tick_fast = 1'b0;
    endtask

    task automatic slow(input int n);
        repeat (n) begin @(negedge clk); tick_slow = 1'b1; end
        @(negedge clk); tick_slow = 1'b0;
    endtask

    task automatic irq_chk(input string req, input logic exp);
        @(negedge clk);
        #1 chk(req, 32'(irq), 32'(exp));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 ctrl", 0, 0);
        rd_chk("R1 div", 1, 0);
        rd_chk("R1 stat", 2, 0);
        rd_chk("R1 mask", 3, 0);
        for (int i = 4; i < 7; i++) rd_chk("R1 cmp", i, 32'hFF);
        rd_chk("R1 cap1", 7, 0);
        rd_chk("R1 cap2", 8, 0);
        rd_chk("R1 cnt", 9, 0);
        irq_chk("R1 irq", 1'b0);

        // R2 undefined and misaligned accesses
        wr(12, 32'hFFFF_FFFF);
        wr_addr(4 * 4 + 3, 32'h0);
        for (int i = 10; i < 16; i++) rd_chk("R2 undefined read", i, 0);
        rd_addr(4 * 4 + 1, v); chk("R2 misaligned read", v, 0);
        rd_chk("R2 cmp1 untouched", 4, 32'hFF);
        rd_chk("R2 ctrl untouched", 0, 0);

        // R7 control masking
        wr(0, 32'h0000_7FFE);
        rd_chk("R7 masked bits", 0, 32'h0000_03EA);
        wr(0, 32'hABCD_0000);
        rd_chk("R7 upper bits", 0, 32'hABCD_0000);
        wr(0, 0);

        // R3 divisor width, R6 mask width
        wr(1, 32'hFFFF_F123);
        rd_chk("R3 div 12 bits", 1, 32'h123);
        wr(3, 32'hFF);
        rd_chk("R6 mask 6 bits", 3, 32'h3F);

        // R8 software reset
        wr(1, 5); wr(5, 32'h44);
        wr(0, 32'h243);
        fast(12);
        rd_chk("R8 pre count", 9, 2);
        wr(0, 32'hFFFF_FFFF);
        rd_chk("R8 ctrl kept bits", 0, 32'hFFFF_03C0);
        rd_chk("R8 div", 1, 0);
        rd_chk("R8 stat", 2, 0);
        rd_chk("R8 mask", 3, 0);
        rd_chk("R8 cmp2", 5, 32'hFF);
        rd_chk("R8 cnt", 9, 0);
        irq_chk("R8 irq", 1'b0);
        wr(0, 0);

        // R4 clock-source sweep
        for (int code = 0; code < 8; code++) begin
            int exp;
            wr(0, 0);
            wr(0, 32'h203 | (code << 6));
            fast(5);
            slow(3);
            exp = (code == 1 || code == 2) ? 5 : (code == 4) ? 3 : 0;
            rd_chk($sformatf("R4 source %0d", code), 9, exp);
        end

        // R3 divisor sweep
        for (int p = 0; p < 6; p++) begin
            wr(0, 0);
            wr(1, p);
            wr(0, 32'h243);
            fast(24);
            rd_chk($sformatf("R3 div %0d", p), 9, 24 / (p + 1));
        end
        for (int n = 1; n < 9; n++) begin
            wr(0, 0);
            wr(1, 2);
            wr(0, 32'h243);
            fast(n);
            rd_chk($sformatf("R3 div 2 ticks %0d", n), 9, n / 3);
        end
        wr(0, 0);
        wr(1, 0);

        // R11 / R5 / R12 free-run compares and rollover
        wr(2, 32'h3F);
        wr(4, 10); wr(5, 20); wr(6, 30);
        wr(0, 32'h243);
        fast(10);
        rd_chk("R11 cnt 10", 9, 10);
        rd_chk("R11 flag1", 2, 32'h1);
        fast(10);
        rd_chk("R11 flag2", 2, 32'h3);
        wr(2, 32'h1);
        rd_chk("R5 clear one", 2, 32'h2);
        wr(2, 32'h0);
        rd_chk("R5 zero write", 2, 32'h2);
        fast(10);
        rd_chk("R11 flag3", 2, 32'h6);
        fast(225);
        rd_chk("R12 cnt max", 9, 255);
        rd_chk("R12 no wrap yet", 2, 32'h6);
        fast(1);
        rd_chk("R12 cnt wrapped", 9, 0);
        rd_chk("R12 wrap flag", 2, 32'h26);

        // R6 interrupt gating
        wr(3, 32'h20);
        irq_chk("R6 irq on", 1'b1);
        wr(3, 32'h01);
        irq_chk("R6 irq masked", 1'b0);
        wr(3, 32'h20);

        // R9 enable behaviour
        fast(7);
        rd_chk("R9 cnt 7", 9, 7);
        wr(0, 32'h242);
        irq_chk("R6 irq off when halted", 1'b0);
        fast(5);
        rd_chk("R9 halted holds", 9, 7);
        wr(0, 32'h241);
        rd_chk("R9 resume value", 9, 7);
        irq_chk("R6 irq back", 1'b1);
        fast(2);
        rd_chk("R9 resume counts", 9, 9);
        wr(0, 32'h242);
        wr(0, 32'h243);
        rd_chk("R9 start zeroes", 9, 0);

        // R10 / R13 restart mode
        wr(0, 32'h042);
        wr(2, 32'h3F);
        wr(3, 0);
        wr(0, 32'h043);
        wr(4, 5);
        fast(3);
        rd_chk("R10 cnt 3", 9, 3);
        wr(4, 5);
        rd_chk("R10 cmp1 write zeroes", 9, 0);
        fast(5);
        rd_chk("R13 reach period", 9, 5);
        rd_chk("R11 restart flag", 2, 32'h1);
        fast(1);
        rd_chk("R13 reload", 9, 0);
        fast(4);
        rd_chk("R13 after reload", 9, 4);
        rd_chk("R12 no wrap in restart", 2, 32'h1);

        // R10 free-run: compare-1 write leaves counter
        wr(0, 32'h242);
        wr(0, 32'h241);
        wr(4, 100);
        rd_chk("R10 free-run keeps", 9, 4);
        fast(2);
        rd_chk("R13 free-run counts", 9, 6);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule